// File: doc/BRIEF.md
# Banked Stream Register File

This block is on-chip staging storage for streams that move between SIMD kernels. The storage is split into one bank per lane, and each bank only ever holds the elements that its own lane produces or consumes. In every kernel iteration, all lanes hand over or take one word each, in parallel. Element `k*LANES + i` of a stream therefore lives in bank `i`.

All banks share a single storage port. Every access through it covers one full block row: `BLK_WORDS` words in every bank at the same row address. Several stream buffers take turns on that port, so the one port serves as many logical ports. Each buffer holds two blocks and runs them as a double buffer:

- **Read buffers** fetch the following blocks of their stream on their own, while the lanes drain the other half.
- **Write buffers** collect lane words into one half and hand full halves to the port, while the lanes keep filling the other half.

A stream is started with a pulse that carries a base row and a length in blocks. It finishes with a sticky end flag.

Top module: `srf_banked_top`

## Requirements
- R1: After a synchronous reset, every `rd_valid`, `wr_ready`, `rd_done` and `wr_done` bit is 0.
- R2: Lane `i` occupies bits `[i*WORD_W +: WORD_W]` of a lane bus. In write iteration `k` of a stream with base row `b`, lane `i`'s word is stored in bank `i`, row `b + k/BLK_WORDS`, slot `k%BLK_WORDS`. A read stream with the same base delivers that same word on lane `i` in its iteration `k`, with iterations in increasing order.
- R3: A read buffer fetches its first blocks without any lane request, and never overwrites a half that still holds data. Once both halves are loaded, holding `rd_ready` high delivers `2*BLK_WORDS` iterations on consecutive cycles.
- R4: While `rd_valid` is high and `rd_ready` is low, the lane words stay unchanged and no iteration is consumed.
- R5: A read stream raises `rd_done` after its last iteration is taken and then keeps `rd_valid` low. A write stream raises `wr_done` once its last block has reached the banks, and keeps `wr_ready` low from then on.
- R6: The shared port grants at most one requesting buffer per cycle. Grants rotate round-robin over read buffers 0..N_RD-1, then write buffers 0..N_WR-1. Streams running at the same time each keep their contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | N_RD | Pulse to start a read stream, one bit per read buffer |
| rd_base | input | N_RD*AW | Base row for each read buffer |
| rd_len | input | N_RD*(AW+1) | Length in blocks for each read buffer (at least 1) |
| rd_valid | output | N_RD | Lane words available |
| rd_ready | input | N_RD | Lanes take the current iteration |
| rd_data | output | N_RD*LANES*WORD_W | One word per lane, for each read buffer |
| rd_done | output | N_RD | End of read stream |
| wr_start | input | N_WR | Pulse to start a write stream |
| wr_base | input | N_WR*AW | Base row for each write buffer |
| wr_len | input | N_WR*(AW+1) | Length in blocks for each write buffer (at least 1) |
| wr_valid | input | N_WR | Lanes offer an iteration |
| wr_ready | output | N_WR | Write buffer accepts an iteration |
| wr_data | input | N_WR*LANES*WORD_W | One word per lane, for each write buffer |
| wr_done | output | N_WR | End of write stream |

## Verification
The hardest state to reach is a read buffer whose two halves are both loaded while a lane holds back. The stimulus starts a stream with `rd_ready` low and waits, so the prefetch can only come from the buffer itself. It then checks that the held word stays put before releasing the lanes. Port contention is reached by running two write streams together, then two read streams together with uneven ready patterns, and finally a write stream alongside a read stream. This keeps several buffers requesting the single port in the same cycles.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic {HALF_A = 1'b0, HALF_B = 1'b1} half_e;
endpackage

// File: rtl/srf_rr_arb.sv
module srf_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  logic [PW-1:0] ptr;
  int            gidx;

  always_comb begin
    gnt  = '0;
    gidx = 0;
    for (int off = N - 1; off >= 0; off--) begin
      int idx;
      idx = (int'(ptr) + off) % N;
      if (req[idx]) begin
        gnt      = '0;
        gnt[idx] = 1'b1;
        gidx     = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (|gnt) ptr <= (gidx == N - 1) ? '0 : PW'(gidx + 1);
  end

  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  // R6
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0);
endmodule

// File: rtl/srf_bank_array.sv
module srf_bank_array #(
  parameter int LANES     = 4,
  parameter int WORD_W    = 16,
  parameter int BLK_WORDS = 2,
  parameter int DEPTH     = 16,
  parameter int AW        = 4
) (
  input  logic                              clk,
  input  logic                              en,
  input  logic                              we,
  input  logic [AW-1:0]                     addr,
  input  logic [LANES*BLK_WORDS*WORD_W-1:0] wdata,
  output logic [LANES*BLK_WORDS*WORD_W-1:0] rdata
);
  localparam int BANK_W = BLK_WORDS * WORD_W;

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [BANK_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (en) begin
        if (we) mem[addr] <= wdata[b*BANK_W +: BANK_W];
        else    rdata[b*BANK_W +: BANK_W] <= mem[addr];
      end
    end
  end
endmodule

// File: rtl/srf_rd_sbuf.sv
module srf_rd_sbuf #(
  parameter int LANES     = 4,
  parameter int WORD_W    = 16,
  parameter int BLK_WORDS = 2,
  parameter int AW        = 4,
  parameter int LEN_W     = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic [AW-1:0]                     base,
  input  logic [LEN_W-1:0]                  len,
  output logic                              req,
  input  logic                              gnt,
  output logic [AW-1:0]                     addr,
  input  logic [LANES*BLK_WORDS*WORD_W-1:0] mem_rdata,
  output logic                              lane_valid,
  input  logic                              lane_ready,
  output logic [LANES*WORD_W-1:0]           lane_data,
  output logic                              done
);
  import srf_pkg::*;
  localparam int BANK_W = BLK_WORDS * WORD_W;
  localparam int ROW_W  = LANES * BANK_W;
  localparam int WI_W   = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;

  logic             active, pend;
  logic [AW-1:0]    base_q;
  logic [LEN_W-1:0] len_q, issued, consumed;
  logic [1:0]       half_vld;
  logic [ROW_W-1:0] half_data [2];
  half_e            head, fill, pend_half;
  logic [WI_W-1:0]  widx;

  assign req        = active && !half_vld[fill] && (issued != len_q);
  assign addr       = base_q + issued[AW-1:0];
  assign lane_valid = half_vld[head];

  always_comb begin
    for (int i = 0; i < LANES; i++)
      lane_data[i*WORD_W +: WORD_W] = half_data[head][i*BANK_W + int'(widx)*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; done <= 1'b0; pend <= 1'b0; half_vld <= '0;
      base_q <= '0; len_q <= '0; issued <= '0; consumed <= '0;
      head <= HALF_A; fill <= HALF_A; pend_half <= HALF_A; widx <= '0;
    end else if (start) begin
      active <= 1'b1; done <= 1'b0; pend <= 1'b0; half_vld <= '0;
      base_q <= base; len_q <= len; issued <= '0; consumed <= '0;
      head <= HALF_A; fill <= HALF_A; widx <= '0;
    end else begin
      pend <= gnt;
      if (gnt) begin
        issued    <= issued + 1'b1;
        pend_half <= fill;
        fill      <= half_e'(~fill);
      end
      if (pend) begin
        half_vld[pend_half]  <= 1'b1;
        half_data[pend_half] <= mem_rdata;
      end
      if (lane_valid && lane_ready) begin
        if (widx == WI_W'(BLK_WORDS - 1)) begin
          widx           <= '0;
          half_vld[head] <= 1'b0;
          head           <= half_e'(~head);
          consumed       <= consumed + 1'b1;
          if (consumed + 1'b1 == len_q) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end else begin
          widx <= widx + 1'b1;
        end
      end
    end
  end

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_valid && !lane_ready && !start) |=> (lane_valid && $stable(lane_data)));
  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst) done |-> !lane_valid);
  // R3
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !start) |-> !half_vld[pend_half]);
endmodule

// File: rtl/srf_wr_sbuf.sv
module srf_wr_sbuf #(
  parameter int LANES     = 4,
  parameter int WORD_W    = 16,
  parameter int BLK_WORDS = 2,
  parameter int AW        = 4,
  parameter int LEN_W     = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic [AW-1:0]                     base,
  input  logic [LEN_W-1:0]                  len,
  input  logic                              lane_valid,
  output logic                              lane_ready,
  input  logic [LANES*WORD_W-1:0]           lane_data,
  output logic                              req,
  input  logic                              gnt,
  output logic [AW-1:0]                     addr,
  output logic [LANES*BLK_WORDS*WORD_W-1:0] wdata,
  output logic                              done
);
  import srf_pkg::*;
  localparam int BANK_W = BLK_WORDS * WORD_W;
  localparam int ROW_W  = LANES * BANK_W;
  localparam int WI_W   = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;

  logic             active;
  logic [AW-1:0]    base_q;
  logic [LEN_W-1:0] len_q, accepted, drained;
  logic [1:0]       half_full;
  logic [ROW_W-1:0] half_data [2];
  half_e            tail, drain_h;
  logic [WI_W-1:0]  widx;

  assign lane_ready = active && !half_full[tail] && (accepted != len_q);
  assign req        = half_full[drain_h];
  assign addr       = base_q + drained[AW-1:0];
  assign wdata      = half_data[drain_h];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; done <= 1'b0; half_full <= '0;
      base_q <= '0; len_q <= '0; accepted <= '0; drained <= '0;
      tail <= HALF_A; drain_h <= HALF_A; widx <= '0;
    end else if (start) begin
      active <= 1'b1; done <= 1'b0; half_full <= '0;
      base_q <= base; len_q <= len; accepted <= '0; drained <= '0;
      tail <= HALF_A; drain_h <= HALF_A; widx <= '0;
    end else begin
      if (lane_valid && lane_ready) begin
        for (int i = 0; i < LANES; i++)
          half_data[tail][i*BANK_W + int'(widx)*WORD_W +: WORD_W] <= lane_data[i*WORD_W +: WORD_W];
        if (widx == WI_W'(BLK_WORDS - 1)) begin
          widx            <= '0;
          half_full[tail] <= 1'b1;
          tail            <= half_e'(~tail);
          accepted        <= accepted + 1'b1;
        end else begin
          widx <= widx + 1'b1;
        end
      end
      if (gnt) begin
        half_full[drain_h] <= 1'b0;
        drain_h            <= half_e'(~drain_h);
        drained            <= drained + 1'b1;
        if (drained + 1'b1 == len_q) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  // R5
  done_no_accept_chk: assert property (@(posedge clk) disable iff (rst) done |-> !lane_ready);
  // R5
  drain_bounded_chk: assert property (@(posedge clk) disable iff (rst) drained <= accepted);
endmodule

// File: rtl/srf_banked_top.sv
module srf_banked_top #(
  parameter int LANES     = 4,
  parameter int WORD_W    = 16,
  parameter int BLK_WORDS = 2,
  parameter int DEPTH     = 16,
  parameter int N_RD      = 2,
  parameter int N_WR      = 2,
  parameter int AW        = $clog2(DEPTH),
  parameter int LEN_W     = AW + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_RD-1:0]               rd_start,
  input  logic [N_RD*AW-1:0]            rd_base,
  input  logic [N_RD*LEN_W-1:0]         rd_len,
  output logic [N_RD-1:0]               rd_valid,
  input  logic [N_RD-1:0]               rd_ready,
  output logic [N_RD*LANES*WORD_W-1:0]  rd_data,
  output logic [N_RD-1:0]               rd_done,
  input  logic [N_WR-1:0]               wr_start,
  input  logic [N_WR*AW-1:0]            wr_base,
  input  logic [N_WR*LEN_W-1:0]         wr_len,
  input  logic [N_WR-1:0]               wr_valid,
  output logic [N_WR-1:0]               wr_ready,
  input  logic [N_WR*LANES*WORD_W-1:0]  wr_data,
  output logic [N_WR-1:0]               wr_done
);
  localparam int ROW_W = LANES * BLK_WORDS * WORD_W;
  localparam int BUS_W = LANES * WORD_W;
  localparam int NREQ  = N_RD + N_WR;

  logic [NREQ-1:0]  req, gnt;
  logic [AW-1:0]    rd_addr [N_RD];
  logic [AW-1:0]    wr_addr [N_WR];
  logic [ROW_W-1:0] wr_row  [N_WR];
  logic             m_en, m_we;
  logic [AW-1:0]    m_addr;
  logic [ROW_W-1:0] m_wdata, m_rdata;

  srf_rr_arb #(.N(NREQ)) u_arb (.clk(clk), .rst(rst), .req(req), .gnt(gnt));

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    srf_rd_sbuf #(.LANES(LANES), .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .AW(AW), .LEN_W(LEN_W)) u_rd (
      .clk(clk), .rst(rst), .start(rd_start[r]),
      .base(rd_base[r*AW +: AW]), .len(rd_len[r*LEN_W +: LEN_W]),
      .req(req[r]), .gnt(gnt[r]), .addr(rd_addr[r]), .mem_rdata(m_rdata),
      .lane_valid(rd_valid[r]), .lane_ready(rd_ready[r]),
      .lane_data(rd_data[r*BUS_W +: BUS_W]), .done(rd_done[r]));
  end

  for (genvar w = 0; w < N_WR; w++) begin : g_wr
    srf_wr_sbuf #(.LANES(LANES), .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .AW(AW), .LEN_W(LEN_W)) u_wr (
      .clk(clk), .rst(rst), .start(wr_start[w]),
      .base(wr_base[w*AW +: AW]), .len(wr_len[w*LEN_W +: LEN_W]),
      .lane_valid(wr_valid[w]), .lane_ready(wr_ready[w]),
      .lane_data(wr_data[w*BUS_W +: BUS_W]),
      .req(req[N_RD+w]), .gnt(gnt[N_RD+w]), .addr(wr_addr[w]), .wdata(wr_row[w]),
      .done(wr_done[w]));
  end

  always_comb begin
    m_en    = |gnt;
    m_we    = 1'b0;
    m_addr  = '0;
    m_wdata = '0;
    for (int r = 0; r < N_RD; r++)
      if (gnt[r]) m_addr = rd_addr[r];
    for (int w = 0; w < N_WR; w++)
      if (gnt[N_RD+w]) begin
        m_addr  = wr_addr[w];
        m_we    = 1'b1;
        m_wdata = wr_row[w];
      end
  end

  srf_bank_array #(.LANES(LANES), .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .DEPTH(DEPTH), .AW(AW)) u_banks (
    .clk(clk), .en(m_en), .we(m_we), .addr(m_addr), .wdata(m_wdata), .rdata(m_rdata));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (rd_valid == '0 && wr_ready == '0));
endmodule

// File: tb/srf_banked_top_tb.sv
module srf_banked_top_tb;
  localparam int PERIOD = 10;
  localparam int LANES  = 4;
  localparam int W      = 16;
  localparam int BLK    = 2;
  localparam int AW     = 4;
  localparam int LW     = 5;
  localparam int BUS    = LANES * W;

  logic clk = 0, rst = 1;
  always #(PERIOD/2) clk = ~clk;

  logic          rst_s [2], rrdy [2], wst [2], wv [2];
  logic [AW-1:0] rb [2], wb [2];
  logic [LW-1:0] rl [2], wl [2];
  logic [BUS-1:0] wd [2];
  logic [1:0] rd_start, rd_ready, rd_valid, rd_done, wr_start, wr_valid, wr_ready, wr_done;
  logic [2*AW-1:0] rd_base, wr_base;
  logic [2*LW-1:0] rd_len, wr_len;
  logic [2*BUS-1:0] rd_data, wr_data;

  assign rd_start = {rst_s[1], rst_s[0]};
  assign rd_ready = {rrdy[1], rrdy[0]};
  assign rd_base  = {rb[1], rb[0]};
  assign rd_len   = {rl[1], rl[0]};
  assign wr_start = {wst[1], wst[0]};
  assign wr_valid = {wv[1], wv[0]};
  assign wr_base  = {wb[1], wb[0]};
  assign wr_len   = {wl[1], wl[0]};
  assign wr_data  = {wd[1], wd[0]};

  srf_banked_top u_dut (
    .clk(clk), .rst(rst),
    .rd_start(rd_start), .rd_base(rd_base), .rd_len(rd_len), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_done(rd_done),
    .wr_start(wr_start), .wr_base(wr_base), .wr_len(wr_len), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_done(wr_done));

  int n_cmp = 0, n_bad = 0;
  logic [BUS-1:0] q0 [$];
  logic [BUS-1:0] q1 [$];

  function automatic logic [BUS-1:0] pat(int sid, int k);
    logic [BUS-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*W +: W] = {sid[3:0], k[7:0], i[3:0]};
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [BUS-1:0] act, logic [BUS-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each read handshake (R2)
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid[0] && rrdy[0]) begin
        if (q0.size() == 0) chk(0, "R2 stream0 unexpected", rd_data[0 +: BUS], '0);
        else begin
          logic [BUS-1:0] e;
          e = q0.pop_front();
          chk(rd_data[0 +: BUS] == e, "R2 stream0 data", rd_data[0 +: BUS], e);
        end
      end
      if (rd_valid[1] && rrdy[1]) begin
        if (q1.size() == 0) chk(0, "R2 stream1 unexpected", rd_data[BUS +: BUS], '0);
        else begin
          logic [BUS-1:0] e;
          e = q1.pop_front();
          chk(rd_data[BUS +: BUS] == e, "R2 stream1 data", rd_data[BUS +: BUS], e);
        end
      end
    end
  end

  task automatic wr_stream(int p, int base, int len, int sid);
    @(posedge clk); #1;
    wb[p] = AW'(base); wl[p] = LW'(len); wst[p] = 1;
    @(posedge clk); #1 wst[p] = 0;
    for (int k = 0; k < len*BLK; k++) begin
      wv[p] = 1; wd[p] = pat(sid, k);
      @(negedge clk);
      while (!wr_ready[p]) @(negedge clk);
      @(posedge clk); #1;
    end
    wv[p] = 0;
    while (!wr_done[p]) @(negedge clk);
    chk(wr_done[p] == 1, "R5 wr_done", BUS'(wr_done[p]), 1);
    chk(wr_ready[p] == 0, "R5 wr_ready low after end", BUS'(wr_ready[p]), 0);
  endtask

  task automatic rd_begin(int p, int base, int len, int sid);
    for (int k = 0; k < len*BLK; k++) begin
      if (p == 0) q0.push_back(pat(sid, k)); else q1.push_back(pat(sid, k));
    end
    @(posedge clk); #1;
    rb[p] = AW'(base); rl[p] = LW'(len); rst_s[p] = 1;
    @(posedge clk); #1 rst_s[p] = 0;
  endtask

  task automatic rd_finish(int p);
    while (!rd_done[p]) @(negedge clk);
    @(negedge clk);
    chk(rd_valid[p] == 0, "R5 rd_valid low after end", BUS'(rd_valid[p]), 0);
    chk((p == 0 ? q0.size() : q1.size()) == 0, "R6 all items delivered",
        BUS'(p == 0 ? q0.size() : q1.size()), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [BUS-1:0] held;
    int run;
    for (int p = 0; p < 2; p++) begin
      rst_s[p] = 0; rrdy[p] = 0; wst[p] = 0; wv[p] = 0;
      rb[p] = '0; wb[p] = '0; rl[p] = '0; wl[p] = '0; wd[p] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1
    chk(rd_valid == 0 && wr_ready == 0, "R1 valid/ready", BUS'({rd_valid, wr_ready}), 0);
    chk(rd_done == 0 && wr_done == 0, "R1 done flags", BUS'({rd_done, wr_done}), 0);

    // two write streams contending for the port (R6)
    fork
      wr_stream(0, 0, 3, 1);
      wr_stream(1, 8, 2, 2);
    join

    // prefetch with lanes held back (R3), stall hold (R4)
    rd_begin(0, 0, 3, 1);
    repeat (12) @(negedge clk);
    chk(rd_valid[0] == 1, "R3 prefetch without ready", BUS'(rd_valid[0]), 1);
    held = rd_data[0 +: BUS];
    chk(held == pat(1, 0), "R2 first iteration", held, pat(1, 0));
    repeat (3) @(negedge clk);
    chk(rd_data[0 +: BUS] == held && rd_valid[0], "R4 data held while stalled", rd_data[0 +: BUS], held);
    chk(q0.size() == 6, "R4 nothing consumed while stalled", BUS'(q0.size()), 6);
    @(posedge clk); #1 rrdy[0] = 1;
    run = 0;
    for (int c = 0; c < 2*BLK; c++) begin
      @(negedge clk);
      if (rd_valid[0]) run++;
    end
    chk(run == 2*BLK, "R3 back-to-back delivery", BUS'(run), BUS'(2*BLK));
    rd_finish(0);
    chk(rd_done[0] == 1, "R5 rd_done", BUS'(rd_done[0]), 1);

    // two reads at once with uneven ready patterns (R6)
    rrdy[0] = 0;
    fork
      rd_begin(0, 8, 2, 2);
      rd_begin(1, 0, 3, 1);
    join
    fork
      begin
        for (int c = 0; !(rd_done[0] && rd_done[1]); c++) begin
          @(posedge clk); #1;
          rrdy[0] = c[0];
          rrdy[1] = (c % 3 != 0);
        end
      end
      rd_finish(0);
      rd_finish(1);
    join
    rrdy[0] = 0; rrdy[1] = 0;

    // write and read sharing the port (R6), then read back the new stream (R2)
    fork
      wr_stream(0, 12, 4, 3);
      begin
        rd_begin(0, 8, 2, 2);
        @(posedge clk); #1 rrdy[0] = 1;
        rd_finish(0);
      end
    join
    rd_begin(1, 12, 4, 3);
    @(posedge clk); #1 rrdy[1] = 1;
    rd_finish(1);
    chk(rd_done[1] == 1, "R5 rd_done stream1", BUS'(rd_done[1]), 1);
    summary();
  end
endmodule